// File: doc/BRIEF.md
# Masked register load executor

This block carries out a three-word "masked load" command. The command arrives as a stream of 32-bit words on a valid/ready input. The first word is the instruction word. It names the operation and the target register. The second word is a bit mask and the third word is the data.

Once the data word is in, the block performs a read-modify-write on its internal register file. Each register bit whose mask bit is set takes the matching data bit. Every other bit keeps its old value.

An instruction word that carries any other operation code is dropped alone and flagged. The next word is then treated as a fresh instruction word. A separate read port lets the surrounding logic observe any register at any time.

Top module: `mask_load_exec`

## Requirements
- R1: While `rst_ni` is low and after its release, every register reads zero and `cmd_ready_o` is high, with `done_o` and `illegal_o` low.
- R2: A word is consumed on a rising edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low in the write cycle and in the done cycle of a command.
- R3: An instruction word whose bits 31:28 equal 4'b1100 starts a masked load. The next two consumed words are taken as the mask and then the data.
- R4: Instruction bits 6:0 select the target register (byte offset divided by four, 128 registers). Bits 27:7 have no effect on any result.
- R5: The target register becomes (old & ~mask) | (data & mask).
- R6: The register is written on the edge after the data word is consumed, so the new value is visible on `rd_data_o` one cycle after acceptance. `done_o` is high for exactly that one cycle.
- R7: An instruction word with bits 31:28 other than 4'b1100 raises `illegal_o` in the cycle after it is consumed. It changes no register, and the next word is decoded as an instruction word.
- R8: `done_o` is never high for two cycles in a row, and `done_o` and `illegal_o` are never high together.
- R9: Registers other than the target of a masked load keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_word_i | input | 32 | Command word |
| cmd_ready_o | output | 1 | Block can take a command word |
| rd_addr_i | input | 7 | Observation read address (word index) |
| rd_data_o | output | 32 | Register contents at `rd_addr_i` |
| done_o | output | 1 | One-cycle pulse after a masked write completes |
| illegal_o | output | 1 | One-cycle pulse after a bad opcode word is consumed |

## Verification
The assertions assume that `cmd_valid_i` and `cmd_word_i` carry known values at each rising edge. They also assume that a word counts as taken only when `cmd_ready_o` is high at that edge. The stimulus meets both assumptions by driving the inputs only at falling edges. It holds each word until the edge where ready was seen high, and it keeps every input at a defined value outside transfers. Random opcodes, reserved bits, masks and idle gaps are drawn inside those limits, and directed cases cover all-ones and all-zero masks and the first and last register.

// File: rtl/mld_pkg.sv
package mld_pkg;
  localparam logic [3:0] OPC_MASKLOAD = 4'b1100;

  typedef enum logic [2:0] {
    ST_INSTR,
    ST_MASK,
    ST_DATA,
    ST_WRITE,
    ST_DONE
  } mld_state_e;
endpackage

// File: rtl/mld_ctrl.sv
module mld_ctrl
  import mld_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] data_o,
  output logic              wr_en_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam int OPC_LSB = WORD_W - 4;

  mld_state_e state_q, state_d;
  logic       accept;
  logic       opc_ok;
  logic       unused_rsvd;

  assign unused_rsvd = ^word_i[OPC_LSB-1:ADDR_W];
  assign opc_ok      = (word_i[WORD_W-1:OPC_LSB] == OPC_MASKLOAD);
  assign ready_o     = (state_q == ST_INSTR) || (state_q == ST_MASK) || (state_q == ST_DATA);
  assign accept      = valid_i && ready_o;
  assign wr_en_o     = (state_q == ST_WRITE);
  assign done_o      = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INSTR: if (accept && opc_ok) state_d = ST_MASK;
      ST_MASK:  if (accept) state_d = ST_DATA;
      ST_DATA:  if (accept) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_INSTR;
      default:  state_d = ST_INSTR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INSTR;
      addr_o    <= '0;
      mask_o    <= '0;
      data_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_o <= accept && (state_q == ST_INSTR) && !opc_ok;
      if (accept && state_q == ST_INSTR) addr_o <= word_i[ADDR_W-1:0];
      if (accept && state_q == ST_MASK)  mask_o <= word_i;
      if (accept && state_q == ST_DATA)  data_o <= word_i;
    end
  end

  // R2
  ready_low_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !ready_o);

  // R6
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> done_o);

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mld_merge.sv
module mld_merge #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] new_o
);
  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
    assign new_o[gi] = mask_i[gi] ? data_i[gi] : old_i[gi];
  end
endmodule

// File: rtl/mld_regfile.sv
module mld_regfile #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  // R5
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mask_load_exec.sv
module mask_load_exec #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam int OPC_LSB = WORD_W - 4;

  logic [ADDR_W-1:0] tgt_addr;
  logic [WORD_W-1:0] mask_w, data_w, old_w, new_w;
  logic              wr_en;

  mld_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (cmd_valid_i),
    .word_i   (cmd_word_i),
    .ready_o  (cmd_ready_o),
    .addr_o   (tgt_addr),
    .mask_o   (mask_w),
    .data_o   (data_w),
    .wr_en_o  (wr_en),
    .done_o   (done_o),
    .illegal_o(illegal_o)
  );

  mld_merge #(.WORD_W(WORD_W)) u_merge (
    .old_i (old_w),
    .mask_i(mask_w),
    .data_i(data_w),
    .new_o (new_w)
  );

  mld_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .waddr_i  (tgt_addr),
    .wdata_i  (new_w),
    .raddr_a_i(tgt_addr),
    .rdata_a_o(old_w),
    .raddr_b_i(rd_addr_i),
    .rdata_b_o(rd_data_o)
  );

  // R7
  illegal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(cmd_valid_i && cmd_ready_o && cmd_word_i[WORD_W-1:OPC_LSB] != mld_pkg::OPC_MASKLOAD));

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  // R2
  ready_low_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);
endmodule

// File: tb/mask_load_exec_test.sv
module mask_load_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done, illegal;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [128];

  always #10 clk = ~clk;

  mask_load_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .cmd_ready_o(cmd_ready), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_o(done), .illegal_o(illegal)
  );

  function automatic logic [31:0] merge_exp(logic [31:0] o, logic [31:0] m, logic [31:0] d);
    return (o & ~m) | (d & m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(logic [6:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic put(logic [31:0] w);
    cmd_valid = 1'b1;
    cmd_word  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = $urandom;
  endtask

  task automatic gap();
    int n = $urandom_range(0, 2);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mask_load(logic [6:0] a, logic [20:0] rsvd, logic [31:0] m, logic [31:0] d, bit gaps);
    logic [31:0] v;
    logic [6:0]  other;
    put({4'b1100, rsvd, a});                 // R3 R4
    if (gaps) gap();
    put(m);
    if (gaps) gap();
    put(d);
    model[a] = merge_exp(model[a], m, d);
    check("R2 ready low in write cycle", {31'd0, cmd_ready}, 32'd0);
    check("R6 no done before write", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R6 done pulse", {31'd0, done}, 32'd1);
    check("R8 no illegal with done", {31'd0, illegal}, 32'd0);
    read_reg(a, v);
    check("R5 merged value", v, model[a]);
    other = a + 7'd1 + 7'($urandom_range(0, 125));
    read_reg(other, v);
    check("R9 other register", v, model[other]);
    @(negedge clk);
    check("R8 done single", {31'd0, done}, 32'd0);
    check("R2 ready after done", {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic bad_word(logic [31:0] w);
    logic [31:0] v;
    put(w);
    check("R7 illegal pulse", {31'd0, illegal}, 32'd1);
    check("R7 ready stays", {31'd0, cmd_ready}, 32'd1);
    read_reg(w[6:0], v);
    check("R7 no register change", v, model[w[6:0]]);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4663));
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    read_reg(7'd5, v);
    check("R1 reg zero in reset", v, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
    check("R1 done low", {31'd0, done}, 32'd0);
    check("R1 illegal low", {31'd0, illegal}, 32'd0);
    read_reg(7'd127, v);
    check("R1 reg zero", v, 32'd0);

    // directed corners
    mask_load(7'd0, 21'h0, 32'hFFFF_FFFF, 32'hA5A5_1234, 1'b0);
    mask_load(7'd127, 21'h1F_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 1'b0);
    mask_load(7'd127, 21'h0, 32'h0000_0000, 32'h1111_1111, 1'b0);
    mask_load(7'd0, 21'h0A_5A5A, 32'h0000_FF00, 32'h0000_00FF, 1'b0);
    bad_word(32'h0000_0000);
    bad_word(32'hD000_007F);
    bad_word(32'h4000_0000);
    // R7: after a bad word, next word decodes as instruction
    mask_load(7'd3, 21'h0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 1'b1);

    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 4) == 0) begin
        logic [3:0] op;
        op = 4'($urandom_range(0, 14));
        if (op == 4'b1100) op = 4'b1111;
        bad_word({op, 28'($urandom)});
      end else begin
        mask_load(7'($urandom), 21'($urandom), $urandom, $urandom, 1'b1);
      end
    end

    // R9 full sweep
    for (int i = 0; i < 128; i++) begin
      read_reg(7'(i), v);
      check("R9 final register contents", v, model[i]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule